// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block is a six-entry byte queue that sits between a memory fetch engine and an instruction decoder. While the bus is granted to it and the queue has room, it issues two-byte fetch requests at a running fetch pointer. It places the returned bytes at the tail of the queue. The decoder sees the count of valid bytes and the oldest six bytes side by side, so an instruction of one to six bytes can be assembled in one look. The decoder then removes any number of bytes from zero to six in a single cycle.

A control transfer drives a flush together with a new start address. The flush empties the queue in one cycle and reloads the fetch pointer. A fetch already in flight at that moment is allowed to complete on the bus, but its data is dropped. At most one fetch is outstanding at any time. A write and a removal can occur in the same cycle, and both take effect.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted and after it is released, the byte count is 0, every head byte reads 0, the fetch pointer equals RESET_ADDR (0), and no request is issued during reset.
- R2: `fetch_req_o` is high exactly when `bus_grant_i` is high, `flush_i` is low, no fetch is outstanding, and the current count is at most DEPTH-2 (4).
- R3: Each issued request uses the current `fetch_addr_o`, and the pointer then advances by 2, wrapping modulo 2^ADDR_W.
- R4: A response to a live request appends `rsp_data_i[7:0]` first and `rsp_data_i[15:8]` second. Head byte k sits at `head_o[8k+7:8k]`, with byte 0 the oldest, and every byte position at or above the count reads 0.
- R5: `take_i` removes that many bytes from the head, and the remaining bytes move toward byte 0 in order. A value above the count is clamped to the count.
- R6: When a removal and a write fall in the same cycle, the new count is the old count minus the removed bytes plus 2, and the written bytes follow the kept bytes.
- R7: A flush makes the count 0 and all head bytes 0 on the next cycle, loads `fetch_addr_o` with `flush_addr_i`, and suppresses any request in that cycle.
- R8: A response for a request issued before a flush is discarded, including one that arrives in the flush cycle itself. No new request is issued until that response has returned.
- R9: The count never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Control-transfer flush |
| flush_addr_i | input | ADDR_W (20) | New fetch start address, used with flush |
| bus_grant_i | input | 1 | Bus is free for instruction fetch |
| fetch_req_o | output | 1 | Two-byte fetch request, accepted in the same cycle |
| fetch_addr_o | output | ADDR_W (20) | Current fetch pointer, and the address of a request |
| rsp_valid_i | input | 1 | Fetch data returns for the outstanding request |
| rsp_data_i | input | 16 | Returned bytes, lower address in bits 7:0 |
| take_i | input | 3 | Bytes the decoder removes this cycle (0 to 6) |
| count_o | output | 3 | Valid bytes held |
| head_o | output | 48 | Oldest six bytes, byte 0 in bits 7:0 |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a decoder removal and a response write. The second is a flush and a response that is still in flight, or that returns in that very cycle. The bench runs a grid of response latencies, grant duty patterns and removal sequences, and it flushes at phases that move against the request timing. Some flush targets sit near the top of the address space, so the pointer wraps. In every cycle, a model of the queue contents written from the requirements is compared against the count, the head bytes, the request and the pointer.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] qbyte_t;
endpackage

// File: rtl/pq_rst_sync.sv
module pq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/pq_fetch.sv
module pq_fetch #(
  parameter int DEPTH      = 6,
  parameter int FETCH      = 2,
  parameter int ADDR_W     = 20,
  parameter int RESET_ADDR = 0,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              grant_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              rsp_valid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o
);
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic pend_q, pend_n;
  logic stale_q, stale_n;
  logic room, en;

  always_comb begin
    room    = int'(count_i) <= DEPTH - FETCH;
    req_o   = rst_ni && grant_i && !flush_i && !pend_q && room;
    wr_en_o = rsp_valid_i && pend_q && !stale_q && !flush_i;
    addr_n  = addr_q;
    if (flush_i)    addr_n = flush_addr_i;
    else if (req_o) addr_n = addr_q + ADDR_W'(FETCH);
    pend_n  = req_o ? 1'b1 : (rsp_valid_i ? 1'b0 : pend_q);
    stale_n = flush_i ? (pend_q && !rsp_valid_i) : (rsp_valid_i ? 1'b0 : stale_q);
    en      = flush_i || req_o || rsp_valid_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= ADDR_W'(RESET_ADDR);
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (en) begin
      addr_q  <= addr_n;
      pend_q  <= pend_n;
      stale_q <= stale_n;
    end
  end

  assign addr_o = addr_q;

  assert_req_room_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    req_o |-> (int'(count_i) <= DEPTH - FETCH));
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    req_o |=> !req_o);
  assert_flush_ptr_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> addr_q == $past(flush_addr_i));
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_o && !flush_i) |=> addr_q == $past(addr_q) + ADDR_W'(FETCH));
endmodule

// File: rtl/pq_store.sv
module pq_store
  import pq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int FETCH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [CNT_W-1:0]        take_i,
  input  logic                    wr_en_i,
  input  logic [FETCH*BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]        count_o,
  output logic [DEPTH*BYTE_W-1:0] head_o
);
  qbyte_t mem_q [DEPTH];
  qbyte_t mem_n [DEPTH];
  logic [CNT_W-1:0] count_q, count_n;
  int   take_eff, keep;
  logic upd;

  always_comb begin
    take_eff = (int'(take_i) > int'(count_q)) ? int'(count_q) : int'(take_i);
    keep     = int'(count_q) - take_eff;
    for (int i = 0; i < DEPTH; i++) begin
      mem_n[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (j == i + take_eff && j < int'(count_q)) mem_n[i] = mem_q[j];
      for (int b = 0; b < FETCH; b++)
        if (wr_en_i && i == keep + b) mem_n[i] = wr_data_i[b*BYTE_W +: BYTE_W];
    end
    count_n = CNT_W'(keep + (wr_en_i ? FETCH : 0));
    if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) mem_n[i] = '0;
      count_n = '0;
    end
    upd = flush_i || wr_en_i || (take_eff != 0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (upd) begin
      count_q <= count_n;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_head
    assign head_o[g*BYTE_W +: BYTE_W] = mem_q[g];
  end
  assign count_o = count_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    int'(count_q) <= DEPTH);
  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> count_q == '0);
  assert_write_not_flushed_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_i |-> !flush_i);
  assert_take_write_count_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && int'(take_i) <= int'(count_q))
      |=> int'(count_q) == int'($past(count_q)) - int'($past(take_i)) + FETCH);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH      = 6,
  parameter int FETCH      = 2,
  parameter int ADDR_W     = 20,
  parameter int RESET_ADDR = 0,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int HEAD_W    = DEPTH * pq_pkg::BYTE_W,
  localparam int RSP_W     = FETCH * pq_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              bus_grant_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              rsp_valid_i,
  input  logic [RSP_W-1:0]  rsp_data_i,
  input  logic [CNT_W-1:0]  take_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [HEAD_W-1:0] head_o
);
  logic rst_ni;
  logic wr_en;

  pq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  pq_fetch #(
    .DEPTH(DEPTH), .FETCH(FETCH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .grant_i      (bus_grant_i),
    .count_i      (count_o),
    .rsp_valid_i  (rsp_valid_i),
    .req_o        (fetch_req_o),
    .addr_o       (fetch_addr_o),
    .wr_en_o      (wr_en)
  );

  pq_store #(
    .DEPTH(DEPTH), .FETCH(FETCH)
  ) u_store (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .take_i    (take_i),
    .wr_en_i   (wr_en),
    .wr_data_i (rsp_data_i),
    .count_o   (count_o),
    .head_o    (head_o)
  );
endmodule

// File: tb/tb_prefetch_queue.sv
`timescale 1ns/1ps
module tb_prefetch_queue;
  localparam int DEPTH = 6;
  localparam int FETCH = 2;
  localparam int AW    = 20;
  localparam int CW    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, flush, grant, req, rv;
  logic [AW-1:0] faddr, addr;
  logic [15:0] rdata;
  logic [CW-1:0] take, count;
  logic [47:0] head;

  prefetch_queue dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_addr_i(faddr),
    .bus_grant_i(grant), .fetch_req_o(req), .fetch_addr_o(addr),
    .rsp_valid_i(rv), .rsp_data_i(rdata), .take_i(take),
    .count_o(count), .head_o(head)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] mq [DEPTH];
  int mcount = 0;
  logic [AW-1:0] maddr = '0;
  bit mpend = 0, mstale = 0;
  int tmr = 0, lat = 1;
  logic [AW-1:0] raddr = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(logic [AW-1:0] a);
    return 8'(int'(a) * 7 + 3);
  endfunction

  function automatic logic [47:0] exp_head();
    logic [47:0] v = '0;
    for (int k = 0; k < DEPTH; k++) if (k < mcount) v[k*8 +: 8] = mq[k];
    return v;
  endfunction

  task automatic cycle(bit g, int tk, bit fl, logic [AW-1:0] fa);
    bit expreq;
    int ce;
    @(negedge clk);
    rv = 1'b0;
    if (tmr == 1) begin
      rv = 1'b1;
      rdata = {mbyte(raddr + 1'b1), mbyte(raddr)};
      tmr = 0;
    end else if (tmr > 1) tmr--;
    grant = g; take = CW'(tk); flush = fl; faddr = fa;
    #1;
    expreq = g && !fl && !mpend && (mcount <= DEPTH - FETCH);
    chk("R2 R8 request", 64'(req), 64'(expreq));
    chk("R3 R7 fetch pointer", 64'(addr), 64'(maddr));
    chk("R5 R6 R9 count", 64'(count), 64'(mcount));
    chk("R4 R5 head bytes", 64'(head), 64'(exp_head()));
    if (expreq) begin tmr = lat; raddr = maddr; end
    if (fl) begin
      mcount = 0;
      maddr  = fa;
      mstale = mpend && !rv;
      mpend  = mpend && !rv;
    end else begin
      ce = (tk > mcount) ? mcount : tk;
      for (int k = 0; k < DEPTH; k++) mq[k] = (k + ce < mcount) ? mq[k + ce] : 8'h00;
      mcount -= ce;
      if (rv && mpend && !mstale) begin
        mq[mcount] = rdata[7:0];
        mq[mcount + 1] = rdata[15:8];
        mcount += 2;
      end
      if (rv) begin mpend = 0; mstale = 0; end
      if (expreq) begin mpend = 1; maddr = maddr + AW'(FETCH); end
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) mq[k] = 8'h00;
    rst_n = 1'b0; flush = 1'b0; grant = 1'b1; take = '0; faddr = '0;
    rv = 1'b0; rdata = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset, no request even with grant high
    chk("R1 reset request", 64'(req), 64'd0);
    chk("R1 reset count", 64'(count), 64'd0);
    chk("R1 reset head", 64'(head), 64'd0);
    chk("R1 reset pointer", 64'(addr), 64'd0);
    grant = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release count", 64'(count), 64'd0);
    chk("R1 after release pointer", 64'(addr), 64'd0);
    for (int l = 1; l <= 3; l++) begin
      for (int gp = 1; gp <= 3; gp++) begin
        for (int cm = 0; cm <= 6; cm++) begin
          int run;
          logic [AW-1:0] start;
          run = (l * 3 + gp) * 7 + cm;
          lat = l;
          start = (run % 2 == 1) ? 20'hFFFFA : AW'(run * 64);
          for (int c = 0; c < 60; c++) begin
            bit g, fl;
            int tk;
            g  = (gp == 1) || ((c % gp) != 0);
            tk = (cm == 0) ? 0 : ((c * cm + run) % 7);
            fl = (c == 0) || ((c % 17) == (run % 5) + 3);
            cycle(g, tk, fl, start + AW'(c * 2));
          end
        end
      end
    end
    // drain: stop fetching and remove everything, queue must empty
    cycle(1'b0, 6, 1'b0, '0);
    cycle(1'b0, 6, 1'b0, '0);
    cycle(1'b0, 0, 1'b0, '0);
    chk("R5 drained count", 64'(count), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule